// File: doc/BRIEF.md
# Two-Phase Shift-Add Decimating Filter Element

This block is one processing element of a lifting-free discrete wavelet transform datapath. Each clock it can accept a pair of samples, the even-indexed one and the odd-indexed one of a 1-D signal. It returns one filtered, 2:1 decimated result per accepted pair. The result is the sum of two short two-tap convolutions, one over the even stream and one over the odd stream. Filtering and decimation therefore happen in the same step, and the element never computes the outputs that decimation would discard.

The four coefficients are fixed. They are quantized approximations of the biorthogonal 9/7 analysis filters, and each one is written as at most three signed powers of two. Every product is a hardwired shift followed by an add or a subtract. All partial products meet in a carry-save reduction and one final adder, so the element has no multiplier. A single parameter selects the low-pass tap bank or the high-pass tap bank. The accumulator is 28 bits wide: 16 data bits, 4 guard bits and 8 fraction bits. The result is scaled back to 16 bits by truncation toward zero and then saturated.

Top module: `pdf_decim_pe`

## Requirements
- R1: A pair presented with `smp_vld_i` high at a rising edge produces `res_vld_o` high after exactly the second rising edge that follows it. `res_vld_o` is high only in that case, so there is exactly one result per accepted pair.
- R2: With `HIGH_PASS=0`, the result is trunc0((78·e[n] − 7·e[n−1] + 164·o[n] − 19·o[n−1]) / 256). In this formula, e and o are the even and odd inputs as signed 16-bit values, n−1 is the previously accepted pair, and trunc0 truncates toward zero.
- R3: With `HIGH_PASS=1`, the same form holds with the weights −72 for e[n], 12 for e[n−1], 152 for o[n] and −18 for o[n−1].
- R4: The history taps advance only on accepted pairs. While `smp_vld_i` is low, the history does not change, `res_vld_o` stays low in the matching output cycle, and `res_data_o` holds its last value.
- R5: Negative sums that are not multiples of 256 round toward zero, not toward minus infinity. For example, o[n] = −1 gives 0 and o[n] = −2 gives −1 in the low-pass bank.
- R6: A result above 32767 is delivered as 32767. A result below −32768 is delivered as −32768.
- R7: While reset is active and in the first cycle after it, `res_vld_o` is 0 and `res_data_o` is 0. The history taps are cleared, so the first pair after reset sees zero history.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_vld_i | input | 1 | Sample pair is present this cycle |
| smp_even_i | input | DATA_W | Even-indexed sample, two's complement |
| smp_odd_i | input | DATA_W | Odd-indexed sample, two's complement |
| res_vld_o | output | 1 | Result is present this cycle |
| res_data_o | output | DATA_W | Decimated filter result, two's complement |

## Verification
A corrupted shift amount or sign in one term biases the result of the tap that holds it. It shows up two cycles after the first pair that drives a non-zero value into that tap. The bench therefore applies single-tap impulses and a dense grid of values through both banks.

A history register that advances on an idle cycle shows up as a wrong weighted term in the first result after a gap. A missed reset clear appears in the very first result after reset.

Rounding and saturation faults appear only for negative fractional sums and for extreme inputs. Both cases are driven on purpose.

// File: rtl/pdf_pkg.sv
package pdf_pkg;

    // One signed power-of-two term: {op[1:0], shift[3:0]}.
    // The term value is op * 2^-shift.
    localparam int TERM_W        = 6;
    localparam int TERMS_PER_TAP = 3;
    localparam int TAPS          = 4;
    localparam int TAP_W         = TERM_W * TERMS_PER_TAP;
    localparam int BANK_W        = TAP_W * TAPS;

    // Roles of the tap slots inside a bank.
    localparam int TAP_ODD_NOW  = 0;
    localparam int TAP_EVEN_NOW = 1;
    localparam int TAP_ODD_OLD  = 2;
    localparam int TAP_EVEN_OLD = 3;

    typedef enum logic [1:0] {
        TERM_NONE = 2'b00,
        TERM_ADD  = 2'b01,
        TERM_SUB  = 2'b10
    } term_op_e;

    function automatic logic [TERM_W-1:0] mk_term(term_op_e op, int unsigned sh);
        return {op, 4'(sh)};
    endfunction

    // Bank layout is {tap3, tap2, tap1, tap0}, each tap is {term2, term1, term0}.
    // Low-pass weights in 1/256 units: 164, 78, -19, -7.
    localparam logic [BANK_W-1:0] BANK_LOW = {
        mk_term(TERM_NONE, 0), mk_term(TERM_ADD, 8), mk_term(TERM_SUB, 5),
        mk_term(TERM_ADD, 8),  mk_term(TERM_SUB, 6), mk_term(TERM_SUB, 4),
        mk_term(TERM_SUB, 7),  mk_term(TERM_ADD, 4), mk_term(TERM_ADD, 2),
        mk_term(TERM_ADD, 6),  mk_term(TERM_ADD, 3), mk_term(TERM_ADD, 1)
    };

    // High-pass weights in 1/256 units: 152, -72, -18, 12.
    localparam logic [BANK_W-1:0] BANK_HIGH = {
        mk_term(TERM_NONE, 0), mk_term(TERM_ADD, 6), mk_term(TERM_ADD, 5),
        mk_term(TERM_NONE, 0), mk_term(TERM_SUB, 7), mk_term(TERM_SUB, 4),
        mk_term(TERM_NONE, 0), mk_term(TERM_SUB, 5), mk_term(TERM_SUB, 2),
        mk_term(TERM_SUB, 5),  mk_term(TERM_ADD, 3), mk_term(TERM_ADD, 1)
    };

endpackage

// File: rtl/pdf_tap_shiftadd.sv
module pdf_tap_shiftadd
    import pdf_pkg::*;
#(
    parameter int                 DATA_W   = 16,
    parameter int                 ACC_W    = 28,
    parameter int                 FRAC_W   = 8,
    parameter logic [TAP_W-1:0]   TAP_CODE = '0
) (
    input  logic signed [DATA_W-1:0]              sample_i,
    output logic [TERMS_PER_TAP*ACC_W-1:0]        parts_o
);

    localparam int EXT_W = ACC_W - DATA_W;

    logic signed [ACC_W-1:0] ext;
    assign ext = {{EXT_W{sample_i[DATA_W-1]}}, sample_i};

    for (genvar t = 0; t < TERMS_PER_TAP; t++) begin : g_term
        localparam term_op_e OP  = term_op_e'(TAP_CODE[t*TERM_W+4 +: 2]);
        localparam int       SH  = int'(TAP_CODE[t*TERM_W +: 4]);
        localparam int       LSH = (SH > FRAC_W) ? 0 : (FRAC_W - SH);

        logic signed [ACC_W-1:0] shifted;
        assign shifted = ext <<< LSH;

        if (OP == TERM_ADD) begin : g_add
            assign parts_o[t*ACC_W +: ACC_W] = shifted;
        end else if (OP == TERM_SUB) begin : g_sub
            assign parts_o[t*ACC_W +: ACC_W] = -shifted;
        end else begin : g_none
            assign parts_o[t*ACC_W +: ACC_W] = '0;
        end
    end

endmodule

// File: rtl/pdf_csa_sum.sv
module pdf_csa_sum #(
    parameter int N_OPS = 12,
    parameter int W     = 28
) (
    input  logic [N_OPS*W-1:0] ops_i,
    output logic [W-1:0]       sum_o
);

    logic [W-1:0] sv;
    logic [W-1:0] cv;
    logic [W-1:0] op;
    logic [W-1:0] nc;

    // 3:2 compression chain, one final carry-propagate add.
    always_comb begin
        sv = '0;
        cv = '0;
        op = '0;
        nc = '0;
        for (int i = 0; i < N_OPS; i++) begin
            op = ops_i[i*W +: W];
            nc = ((sv & cv) | (sv & op) | (cv & op)) << 1;
            sv = sv ^ cv ^ op;
            cv = nc;
        end
        sum_o = sv + cv;
    end

endmodule

// File: rtl/pdf_out_round.sv
module pdf_out_round #(
    parameter int ACC_W  = 28,
    parameter int FRAC_W = 8,
    parameter int DATA_W = 16
) (
    input  logic signed [ACC_W-1:0]  acc_i,
    output logic signed [DATA_W-1:0] data_o
);

    localparam int Q_W = ACC_W - FRAC_W;
    localparam logic [ACC_W-1:0] BIAS = {{(ACC_W-FRAC_W){1'b0}}, {FRAC_W{1'b1}}};
    localparam logic signed [Q_W-1:0] MAXQ =
        {{(Q_W-DATA_W+1){1'b0}}, {(DATA_W-1){1'b1}}};
    localparam logic signed [Q_W-1:0] MINQ =
        {{(Q_W-DATA_W+1){1'b1}}, {(DATA_W-1){1'b0}}};

    logic signed [ACC_W-1:0] biased;
    logic signed [Q_W-1:0]   quot;

    always_comb begin
        // Bias negative sums so the arithmetic shift truncates toward zero.
        biased = acc_i[ACC_W-1] ? (acc_i + $signed(BIAS)) : acc_i;
        quot   = biased[ACC_W-1:FRAC_W];
        if (quot > MAXQ) begin
            data_o = {1'b0, {(DATA_W-1){1'b1}}};
        end else if (quot < MINQ) begin
            data_o = {1'b1, {(DATA_W-1){1'b0}}};
        end else begin
            data_o = quot[DATA_W-1:0];
        end
    end

endmodule

// File: rtl/pdf_decim_pe.sv
module pdf_decim_pe
    import pdf_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter int GUARD_W   = 4,
    parameter int FRAC_W    = 8,
    parameter bit HIGH_PASS = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_vld_i,
    input  logic [DATA_W-1:0] smp_even_i,
    input  logic [DATA_W-1:0] smp_odd_i,
    output logic              res_vld_o,
    output logic [DATA_W-1:0] res_data_o
);

    localparam int ACC_W  = DATA_W + GUARD_W + FRAC_W;
    localparam int N_OPS  = TAPS * TERMS_PER_TAP;
    localparam logic [BANK_W-1:0] BANK = HIGH_PASS ? BANK_HIGH : BANK_LOW;

    typedef struct packed {
        logic signed [DATA_W-1:0] even_now;
        logic signed [DATA_W-1:0] odd_now;
        logic signed [DATA_W-1:0] even_old;
        logic signed [DATA_W-1:0] odd_old;
        logic                     stage_vld;
        logic                     res_vld;
        logic signed [DATA_W-1:0] res;
    } pe_state_t;

    pe_state_t st_d;
    pe_state_t st_q;

    logic signed [DATA_W-1:0] tap_in [TAPS];
    logic [N_OPS*ACC_W-1:0]   parts;
    logic [ACC_W-1:0]         acc_sum;
    logic signed [DATA_W-1:0] rounded;

    assign tap_in[TAP_ODD_NOW]  = st_q.odd_now;
    assign tap_in[TAP_EVEN_NOW] = st_q.even_now;
    assign tap_in[TAP_ODD_OLD]  = st_q.odd_old;
    assign tap_in[TAP_EVEN_OLD] = st_q.even_old;

    for (genvar k = 0; k < TAPS; k++) begin : g_tap
        pdf_tap_shiftadd #(
            .DATA_W  (DATA_W),
            .ACC_W   (ACC_W),
            .FRAC_W  (FRAC_W),
            .TAP_CODE(BANK[k*TAP_W +: TAP_W])
        ) u_tap (
            .sample_i(tap_in[k]),
            .parts_o (parts[k*TERMS_PER_TAP*ACC_W +: TERMS_PER_TAP*ACC_W])
        );
    end

    pdf_csa_sum #(
        .N_OPS(N_OPS),
        .W    (ACC_W)
    ) u_sum (
        .ops_i(parts),
        .sum_o(acc_sum)
    );

    pdf_out_round #(
        .ACC_W (ACC_W),
        .FRAC_W(FRAC_W),
        .DATA_W(DATA_W)
    ) u_round (
        .acc_i (acc_sum),
        .data_o(rounded)
    );

    always_comb begin
        st_d           = st_q;
        st_d.stage_vld = smp_vld_i;
        if (smp_vld_i) begin
            st_d.even_old = st_q.even_now;
            st_d.odd_old  = st_q.odd_now;
            st_d.even_now = smp_even_i;
            st_d.odd_now  = smp_odd_i;
        end
        st_d.res_vld = st_q.stage_vld;
        if (st_q.stage_vld) begin
            st_d.res = rounded;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign res_vld_o  = st_q.res_vld;
    assign res_data_o = st_q.res;

endmodule

// File: rtl/pdf_decim_pe_chk.sv
module pdf_decim_pe_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              smp_vld_i,
    input logic [DATA_W-1:0] smp_even_i,
    input logic [DATA_W-1:0] smp_odd_i,
    input logic              res_vld_o,
    input logic [DATA_W-1:0] res_data_o
);

    logic [1:0] age_q;
    logic [1:0] zrun_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            age_q <= 2'd0;
        end else if (age_q != 2'd3) begin
            age_q <= age_q + 2'd1;
        end
    end

    // Count of recent all-zero pairs; cleared history counts as one.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            zrun_q <= 2'd1;
        end else if (smp_vld_i) begin
            if (smp_even_i == '0 && smp_odd_i == '0) begin
                zrun_q <= (zrun_q == 2'd2) ? 2'd2 : zrun_q + 2'd1;
            end else begin
                zrun_q <= 2'd0;
            end
        end
    end

    p_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q >= 2'd2) |-> (res_vld_o == $past(smp_vld_i, 2)));

    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q >= 2'd1 && !res_vld_o) |-> $stable(res_data_o));

    p_reset_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == 2'd0) |-> (!res_vld_o && res_data_o == '0));

    p_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q >= 2'd2 && res_vld_o && $past(zrun_q) == 2'd2) |-> (res_data_o == '0));

endmodule

bind pdf_decim_pe pdf_decim_pe_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .smp_vld_i (smp_vld_i),
    .smp_even_i(smp_even_i),
    .smp_odd_i (smp_odd_i),
    .res_vld_o (res_vld_o),
    .res_data_o(res_data_o)
);

// File: tb/test_pdf_decim_pe.sv
`timescale 1ns/1ps
module test_pdf_decim_pe;

    localparam int DW = 16;

    logic          clk   = 1'b0;
    logic          rst_n = 1'b0;
    logic          vld   = 1'b0;
    logic [DW-1:0] ev    = '0;
    logic [DW-1:0] od    = '0;
    logic          vld_lp, vld_hp;
    logic [DW-1:0] dat_lp, dat_hp;

    int    checks = 0;
    int    failures = 0;
    bit    done = 1'b0;
    int    hist_e, hist_o;
    bit    s0_v, s1_v;
    int    s0_lp, s0_hp, s1_lp, s1_hp, held_lp, held_hp;
    string s0_tag, s1_tag;

    always #2.5 clk = ~clk;

    pdf_decim_pe #(.HIGH_PASS(1'b0)) i_pdf_decim_pe (
        .clk(clk), .rst_n(rst_n), .smp_vld_i(vld), .smp_even_i(ev), .smp_odd_i(od),
        .res_vld_o(vld_lp), .res_data_o(dat_lp)
    );

    pdf_decim_pe #(.HIGH_PASS(1'b1)) i_pdf_decim_pe_hp (
        .clk(clk), .rst_n(rst_n), .smp_vld_i(vld), .smp_even_i(ev), .smp_odd_i(od),
        .res_vld_o(vld_hp), .res_data_o(dat_hp)
    );

    // Weights in 1/256 units from R2 (low) and R3 (high).
    function automatic int model(bit hp, int e, int ep, int o, int op);
        int acc, q;
        if (hp) acc = -72 * e + 12 * ep + 152 * o - 18 * op;
        else    acc =  78 * e -  7 * ep + 164 * o - 19 * op;
        q = acc / 256;               // truncates toward zero (R5)
        if (q > 32767)  q = 32767;   // R6
        if (q < -32768) q = -32768;  // R6
        return q;
    endfunction

    task automatic chk(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic check_out();
        chk("R1", "low valid",  int'(vld_lp), int'(s1_v));
        chk("R1", "high valid", int'(vld_hp), int'(s1_v));
        if (s1_v) begin
            chk(s1_tag, "low data",  int'($signed(dat_lp)), s1_lp);
            chk(s1_tag, "high data", int'($signed(dat_hp)), s1_hp);
            held_lp = s1_lp;
            held_hp = s1_hp;
        end else begin
            chk("R4", "low hold",  int'($signed(dat_lp)), held_lp);
            chk("R4", "high hold", int'($signed(dat_hp)), held_hp);
        end
    endtask

    task automatic step(bit v, int e, int o, string tag);
        @(negedge clk);
        check_out();
        s1_v = s0_v; s1_lp = s0_lp; s1_hp = s0_hp; s1_tag = s0_tag;
        s0_v = v; s0_tag = tag;
        if (v) begin
            s0_lp = model(1'b0, e, hist_e, o, hist_o);
            s0_hp = model(1'b1, e, hist_e, o, hist_o);
            hist_e = e;
            hist_o = o;
        end
        vld = v;
        ev  = 16'(e);
        od  = 16'(o);
    endtask

    task automatic clear_model();
        hist_e = 0; hist_o = 0;
        s0_v = 0; s1_v = 0;
        held_lp = 0; held_hp = 0;
        s0_tag = "R1"; s1_tag = "R1";
    endtask

    task automatic reset_check();
        chk("R7", "low valid in reset",  int'(vld_lp), 0);
        chk("R7", "low data in reset",   int'($signed(dat_lp)), 0);
        chk("R7", "high valid in reset", int'(vld_hp), 0);
        chk("R7", "high data in reset",  int'($signed(dat_hp)), 0);
    endtask

    task automatic drain();
        step(1'b0, 0, 0, "R4");
        step(1'b0, 0, 0, "R4");
        step(1'b0, 0, 0, "R4");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int vals[12] = '{-32768, -20000, -4097, -513, -255, -1, 0, 1, 257, 4095, 12345, 32767};
        int unsigned seed;
        clear_model();
        repeat (4) @(negedge clk);
        reset_check();                                  // R7
        @(negedge clk);
        rst_n = 1'b1;

        // Single-tap impulses: each weight seen alone (R2, R3).
        step(1'b1, 256, 0, "R2");
        step(1'b1, 0, 0, "R2");
        step(1'b1, 0, 256, "R3");
        step(1'b1, 0, 0, "R3");
        drain();

        // Grid sweep over both phases, history chained (R2, R3).
        foreach (vals[i]) begin
            foreach (vals[j]) begin
                step(1'b1, vals[i], vals[j], "R2");
            end
        end
        drain();

        // Small values around zero exercise rounding (R5).
        step(1'b1, 0, 0, "R5");
        step(1'b1, 0, -1, "R5");
        step(1'b1, 0, -2, "R5");
        for (int a = -3; a <= 3; a++) begin
            for (int b = -3; b <= 3; b++) begin
                step(1'b1, a, b, "R5");
            end
        end
        drain();

        // Saturation at both rails (R6).
        step(1'b1, -32768, -32768, "R6");
        step(1'b1, 32767, 32767, "R6");
        step(1'b1, 32767, 32767, "R6");
        step(1'b1, -32768, -32768, "R6");
        step(1'b1, -32768, -32768, "R6");
        drain();

        // Random stream with idle gaps: history must not move on gaps (R4).
        seed = 32'h1234_5678;
        for (int n = 0; n < 400; n++) begin
            int e, o;
            bit v;
            seed = seed * 1103515245 + 12345;
            e = int'(seed[30:15]) - 32768;
            seed = seed * 1103515245 + 12345;
            o = int'(seed[30:15]) - 32768;
            v = (seed[5:4] != 2'b00);
            step(v, e, o, "R4");
        end
        drain();

        // Reset in the middle of a stream clears history (R7).
        step(1'b1, 20000, -15000, "R7");
        step(1'b1, 9000, 7000, "R7");
        @(negedge clk);
        rst_n = 1'b0;
        vld = 1'b0;
        @(negedge clk);
        reset_check();
        clear_model();
        rst_n = 1'b1;
        step(1'b1, 1000, 1000, "R7");
        drain();

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule